// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the internal word address used during a four-beat burst. When either of two active-low start strobes is sampled low on a rising clock edge, the block captures an external address. On each later edge where both strobes are high and the active-low advance input is low, it moves to the next beat of the burst. Only the two least significant address bits change. The upper bits keep the value that was loaded.

A static order select input sets how the low bits move. When it is high, the block uses interleaved order: each low-bit pair is the start pair XORed with the beat number. When it is low, the block uses linear order: each low-bit pair is the start pair plus the beat number, modulo four. The block reports the full current address and a two-bit count of the beats advanced since the last load. After four advances the count wraps to zero, and the address returns to its start value.

Top module: `burst_seq`

## Requirements
- R1: After reset, `cur_addr` is 0 and `beat_cnt` is 0.
- R2: On an edge where `strb_p_n` or `strb_c_n` is low, `addr_in` is captured and `beat_cnt` is cleared. The level of `adv_n` on that edge has no effect. A load takes priority over an advance.
- R3: `beat_cnt` increments by one only on an edge where `adv_n` is low and both strobes are high.
- R4: On an edge where `adv_n` is high and both strobes are high, `cur_addr` and `beat_cnt` are held, which suspends the burst.
- R5: With `order_il` = 1, `cur_addr[1:0]` equals the loaded low pair XOR `beat_cnt`. From start 01, successive beats give 01, 00, 11, 10.
- R6: With `order_il` = 0, `cur_addr[1:0]` equals the loaded low pair plus `beat_cnt`, modulo 4. From start 10, successive beats give 10, 11, 00, 01.
- R7: `cur_addr[AW-1:2]` changes only on a load edge.
- R8: The fourth advance after a load sets `beat_cnt` to 0 and returns `cur_addr` to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_p_n | input | 1 | First start strobe, active low |
| strb_c_n | input | 1 | Second start strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| order_il | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | AW | External start address |
| cur_addr | output | AW | Current burst address |
| beat_cnt | output | 2 | Beats advanced since the last load, modulo 4 |

## Verification
There are two pieces of internal state: the stored base address and the beat counter. A fault in either appears on `cur_addr` or `beat_cnt` in the first cycle after the edge that corrupted it, because both outputs are decoded directly from those registers. A counter that steps on a suspend or load edge, or that fails to step on an advance edge, shows as a wrong low address pair on the next sample. A base that is captured wrongly shows in the upper bits at once. The reference model is compared on every clock, so each fault is reported within one cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // interleaved offset: start pair XOR beat number
  function automatic beat_t il_offset(input beat_t start, input beat_t beat);
    return start ^ beat;
  endfunction

  // linear offset: start pair plus beat number, wrapping at the beat width
  function automatic beat_t lin_offset(input beat_t start, input beat_t beat);
    return beat_t'(start + beat);
  endfunction
endpackage

// File: rtl/bseq_strobe_dec.sv
module bseq_strobe_dec (
  input  logic strb_p_n,
  input  logic strb_c_n,
  input  logic adv_n,
  output logic load_ev,
  output logic step_ev,
  output logic hold_ev
);
  always_comb begin
    load_ev = !strb_p_n || !strb_c_n;
    step_ev = !load_ev && !adv_n;
    hold_ev = !load_ev && adv_n;
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_ev,
  input  logic  step_ev,
  output beat_t beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (load_ev) beat <= '0;
    else if (step_ev) beat <= beat + beat_t'(1);
  end
endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base <= '0;
    else if (load_ev) base <= addr_in;
  end
endmodule

// File: rtl/bseq_addr_form.sv
module bseq_addr_form
  import burst_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic [AW-1:0] base,
  input  beat_t         beat,
  input  logic          order_il,
  output logic [AW-1:0] cur_addr
);
  localparam int HI_W = AW - BEAT_W;

  beat_t lo_pair;
  beat_t lo_next;

  assign lo_pair = base[BEAT_W-1:0];

  always_comb begin
    if (order_il) lo_next = il_offset(lo_pair, beat);
    else          lo_next = lin_offset(lo_pair, beat);
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign cur_addr = {base[AW-1:BEAT_W], lo_next};
    end else begin : g_lo_only
      assign cur_addr = lo_next;
    end
  endgenerate
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_p_n,
  input  logic          strb_c_n,
  input  logic          adv_n,
  input  logic          order_il,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    beat_cnt
);
  logic          load_ev;
  logic          step_ev;
  logic          hold_ev;
  beat_t         beat;
  logic [AW-1:0] base;

  bseq_strobe_dec u_dec (
    .strb_p_n (strb_p_n),
    .strb_c_n (strb_c_n),
    .adv_n    (adv_n),
    .load_ev  (load_ev),
    .step_ev  (step_ev),
    .hold_ev  (hold_ev)
  );

  bseq_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .step_ev (step_ev),
    .beat    (beat)
  );

  bseq_base_reg #(.AW(AW)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_ev (load_ev),
    .addr_in (addr_in),
    .base    (base)
  );

  bseq_addr_form #(.AW(AW)) u_form (
    .base     (base),
    .beat     (beat),
    .order_il (order_il),
    .cur_addr (cur_addr)
  );

  assign beat_cnt = beat;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strb_p_n,
  input logic          strb_c_n,
  input logic          adv_n,
  input logic          order_il,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    beat_cnt,
  input logic          load_ev,
  input logic          step_ev,
  input logic          hold_ev
);
  logic [1:0] start_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     start_lo <= 2'b00;
    else if (!strb_p_n || !strb_c_n) start_lo <= addr_in[1:0];
  end

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (beat_cnt == 2'd0) && (cur_addr == $past(addr_in)));

  // R3
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_p_n && strb_c_n && !adv_n) |=> beat_cnt == $past(beat_cnt) + 2'd1);

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ev |=> $stable(beat_cnt));

  // R5
  p_il_r5: assert property (@(posedge clk) disable iff (!rst_n)
    order_il |-> cur_addr[1:0] == (start_lo ^ beat_cnt));

  // R6
  p_lin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !order_il |-> cur_addr[1:0] == 2'(start_lo + beat_cnt));

  // R7
  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_p_n && strb_c_n) |=> $stable(cur_addr[AW-1:2]));

  // R8
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && beat_cnt == 2'd3) |=> cur_addr[1:0] == start_lo);
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strb_p_n (strb_p_n),
  .strb_c_n (strb_c_n),
  .adv_n    (adv_n),
  .order_il (order_il),
  .addr_in  (addr_in),
  .cur_addr (cur_addr),
  .beat_cnt (beat_cnt),
  .load_ev  (load_ev),
  .step_ev  (step_ev),
  .hold_ev  (hold_ev)
);

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
  localparam int AW = 19;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          strb_p_n = 1;
  logic          strb_c_n = 1;
  logic          adv_n = 1;
  logic          order_il = 1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat_cnt;

  int checks = 0;
  int fails = 0;
  int m_base = 0;
  int m_beats = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
    .adv_n(adv_n), .order_il(order_il), .addr_in(addr_in),
    .cur_addr(cur_addr), .beat_cnt(beat_cnt)
  );

  function automatic int exp_addr();
    int lo;
    int s;
    s = m_base % 4;
    if (order_il) lo = s ^ (m_beats % 4);
    else          lo = (s + m_beats) % 4;
    return (m_base - s) + lo;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (int'(cur_addr) != exp_addr() || int'(beat_cnt) != m_beats % 4) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, cur_addr, beat_cnt, exp_addr(), m_beats % 4);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare 2 ns later
  task automatic cyc(input bit p_n, input bit c_n, input bit a_n,
                     input int a, input string tag);
    @(negedge clk);
    strb_p_n = p_n; strb_c_n = c_n; adv_n = a_n; addr_in = AW'(a);
    @(posedge clk);
    if (!p_n || !c_n) begin m_base = a; m_beats = 0; end
    else if (!a_n) m_beats = (m_beats + 1) % 4;
    #2;
    check(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1;
    #1 check("R1 reset state");

    // interleaved, load via first strobe, start low pair 01
    order_il = 1;
    cyc(0, 1, 1, 'h12345, "R2 load first strobe");
    cyc(1, 1, 0, 'h00000, "R5 il beat1 -> 00");
    cyc(1, 1, 1, 'h7FFFF, "R4 suspend holds");
    cyc(1, 1, 1, 'h00000, "R4 suspend again");
    cyc(1, 1, 0, 'h00000, "R5 il beat2 -> 11 R7 upper stable");
    cyc(1, 1, 0, 'h00000, "R5 il beat3 -> 10");
    cyc(1, 1, 0, 'h00000, "R8 wrap to start");

    // linear, load via second strobe with advance low (ignored), start 10
    order_il = 0;
    cyc(1, 0, 0, 'h4ABC6, "R2 load second strobe adv ignored");
    cyc(1, 1, 0, 'h00000, "R6 lin beat1 -> 11");
    cyc(1, 1, 0, 'h00000, "R6 lin beat2 -> 00 R7");
    cyc(1, 1, 1, 'h00000, "R4 lin suspend");
    cyc(1, 1, 0, 'h00000, "R6 lin beat3 -> 01");
    cyc(1, 1, 0, 'h00000, "R8 lin wrap to start");

    // advance with one strobe low is a load, not an advance
    cyc(1, 1, 0, 'h00000, "R3 advance step");
    cyc(0, 1, 0, 'h3FFF3, "R3 strobe blocks advance");
    cyc(0, 0, 0, 'h00002, "R2 both strobes load");
    cyc(1, 1, 0, 'h55555, "R3 advance ignores addr_in R7");

    // interleaved from start 11 through a full loop
    order_il = 1;
    cyc(0, 1, 1, 'h0000B, "R2 load start 11");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 'h0, "R5 il loop R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule